// File: doc/BRIEF.md
# Page Table Entry Validity Checker

This block sits beside a three-level page-table walker. For each level it takes the entry that was just fetched from memory and sorts it into one of three outcomes: a fault that stops the walk, a pointer to the next table, or a leaf that ends the walk with a physical page number. The checks run as a fixed priority chain. First come the reserved bits and the naturally-aligned-power-of-two (NAPOT) bit. Next the two-bit memory-type field is gated by an enable bit. Then come the encoding rules that tell a pointer apart from a leaf. The memory-type enable is taken from one of two environment-configuration bits, and the virtualization mode of the access decides which one.

A small walk sequencer is built in. The walker pulses a start input, and the sequencer begins at the top level. Each entry that is presented while a walk is in progress is classified at the current level. A valid pointer moves the walk down one level. A leaf or any fault ends the walk. A pointer found at the lowest level is a fault. The result is registered and appears one cycle after the entry is accepted.

Entry layout (64 bits): V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7, software bits 9:8, page number 53:10, reserved 60:54, memory type 62:61, NAPOT 63.

Top module: `ptw_pte_checker`

## Requirements
- R1: After reset the block holds `out_valid_o`, `walk_busy_o`, `leaf_o` and `fault_o` at 0, with `fault_cause_o`, `next_ppn_o` and `level_o` at 0.
- R2: An entry with any bit set in the reserved mask faults with cause 1. The default mask is bits 60:54. This check wins over every other check.
- R3: An entry with bit 63 set faults with cause 2 when `napot_ext_en_i` is 0. When that input is 1, bit 63 alone does not fault a leaf.
- R4: A nonzero memory-type field (bits 62:61) faults with cause 3 when the selected enable bit is 0.
- R5: The selected memory-type enable is `henv_mt_en_i` when `virt_i` is 1, and `menv_mt_en_i` when `virt_i` is 0.
- R6: A memory-type value of 3 faults with cause 4 when the selected enable is 1. When the enable is 0, cause 3 is reported instead.
- R7: A pointer entry (V=1, R=W=X=0) faults with cause 5 if D, A, U, bit 63 or either memory-type bit is set. G does not fault a pointer.
- R8: A non-pointer entry with V=0, or with W=1 and R=0, faults with cause 6.
- R9: An entry that has V=1, has R or X set and passes all checks is a leaf: `leaf_o`=1 and `next_ppn_o`= bits 53:10. When a fault is reported, `next_ppn_o` is 0 and `leaf_o` is 0.
- R10: The result registers and a one-cycle `out_valid_o` pulse update on the clock edge after the edge that accepts the entry. `level_o` gives the level at which the entry was checked.
- R11: `walk_start_i` starts a walk at level 2 (`walk_busy_o`=1). A valid pointer moves the level down by one and keeps the walk going. A leaf or a fault ends the walk.
- R12: A pointer entry at level 0 faults with cause 7 and ends the walk.
- R13: `pte_valid_i` is ignored while no walk is in progress, and `walk_start_i` is ignored while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| walk_start_i | input | 1 | Begin a walk at the top level |
| pte_valid_i | input | 1 | Fetched entry present on `pte_i` |
| pte_i | input | 64 | Fetched page table entry |
| virt_i | input | 1 | Access is virtualized |
| menv_mt_en_i | input | 1 | Machine environment memory-type enable |
| henv_mt_en_i | input | 1 | Hypervisor environment memory-type enable |
| napot_ext_en_i | input | 1 | NAPOT extension enabled |
| walk_busy_o | output | 1 | A walk is in progress |
| out_valid_o | output | 1 | One-cycle pulse for a new result |
| leaf_o | output | 1 | Result is a leaf |
| fault_o | output | 1 | Result is a fault |
| fault_cause_o | output | 3 | Fault cause code, 0 when no fault |
| next_ppn_o | output | 44 | Page number of a pointer or leaf |
| level_o | output | 2 | Level at which the result was produced |

## Verification
Single-entry walks cover each fault condition alone and in pairs: reserved plus NAPOT plus memory-type value 3, memory-type value 3 with the enable off, and NAPOT on a pointer. These pairs show that the priority order decides the reported cause. Memory-type entries are repeated under all four combinations of `virt_i` and the two enable bits, which separates a correct enable selection from one that uses the wrong bit or ignores the mode. Multi-level walks check that the reported level goes 2, 1, 0. Two pointers followed by a third pointer tell a valid descent apart from the last-level fault. Overlapping start and entry pulses show which inputs are ignored in each sequencer state.

// File: rtl/ptwchk_pkg.sv
// Package: shared layout constants and types for the entry checker.
// Assumes a 64-bit entry with the page number at bits 53:10.
package ptwchk_pkg;
    localparam int PTE_W     = 64;
    localparam int PPN_LSB   = 10;
    localparam int PPN_W     = 44;
    localparam int MT_LSB    = 61;
    localparam int MT_W      = 2;
    localparam int NAPOT_BIT = 63;
    localparam int BIT_V     = 0;
    localparam int BIT_R     = 1;
    localparam int BIT_W     = 2;
    localparam int BIT_X     = 3;
    localparam int BIT_U     = 4;
    localparam int BIT_A     = 6;
    localparam int BIT_D     = 7;
    localparam int CAUSE_W   = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_RSV      = 3'd1,
        CAUSE_NAPOT    = 3'd2,
        CAUSE_MT_OFF   = 3'd3,
        CAUSE_MT_RSV   = 3'd4,
        CAUSE_PTR_ATTR = 3'd5,
        CAUSE_BAD_ENC  = 3'd6,
        CAUSE_LAST_PTR = 3'd7
    } cause_e;

    typedef enum logic [1:0] {
        KIND_FAULT = 2'd0,
        KIND_PTR   = 2'd1,
        KIND_LEAF  = 2'd2
    } kind_e;
endpackage

// File: rtl/ptwchk_mtype_gate.sv
// Memory-type gate: picks the enable bit by virtualization mode and flags
// a disabled nonzero field or the reserved value. Purely combinational.
module ptwchk_mtype_gate
    import ptwchk_pkg::*;
(
    input  logic [MT_W-1:0] mtype,
    input  logic            virt,
    input  logic            menv_en,
    input  logic            henv_en,
    output logic            mt_off_flt,
    output logic            mt_rsv_flt
);
    localparam logic [MT_W-1:0] MT_RESERVED = {MT_W{1'b1}};

    logic sel_en;

    // Select the enable source and evaluate both field faults.
    always_comb begin
        sel_en     = virt ? henv_en : menv_en;
        mt_off_flt = (mtype != '0) && !sel_en;
        mt_rsv_flt = (mtype == MT_RESERVED);
    end
endmodule

// File: rtl/ptwchk_classify.sv
// Entry classifier: runs the priority chain of fault checks on one entry
// and reports the kind and the cause. Assumes the memory-type faults are
// computed outside. Purely combinational.
module ptwchk_classify
    import ptwchk_pkg::*;
#(
    parameter logic [PTE_W-1:0] RSV_MASK = 64'h1FC0_0000_0000_0000
)(
    input  logic [PTE_W-1:0] pte,
    input  logic             napot_en,
    input  logic             mt_off_flt,
    input  logic             mt_rsv_flt,
    input  logic             last_level,
    output kind_e            kind,
    output cause_e           cause
);
    logic rsv_hit;
    logic napot_hit;
    logic is_ptr;
    logic ptr_attr_hit;
    logic bad_enc;

    // Decode the individual conditions from the entry bits.
    always_comb begin
        rsv_hit      = |(pte & RSV_MASK);
        napot_hit    = pte[NAPOT_BIT] && !napot_en;
        is_ptr       = pte[BIT_V] && !pte[BIT_R] && !pte[BIT_W] && !pte[BIT_X];
        ptr_attr_hit = pte[BIT_D] || pte[BIT_A] || pte[BIT_U] || pte[NAPOT_BIT]
                       || (pte[MT_LSB +: MT_W] != '0);
        bad_enc      = !pte[BIT_V] || (pte[BIT_W] && !pte[BIT_R]);
    end

    // Apply the checks in priority order and pick the outcome.
    always_comb begin
        kind  = KIND_FAULT;
        cause = CAUSE_NONE;
        if (rsv_hit) begin
            cause = CAUSE_RSV;
        end else if (napot_hit) begin
            cause = CAUSE_NAPOT;
        end else if (mt_off_flt) begin
            cause = CAUSE_MT_OFF;
        end else if (mt_rsv_flt) begin
            cause = CAUSE_MT_RSV;
        end else if (is_ptr) begin
            if (ptr_attr_hit) begin
                cause = CAUSE_PTR_ATTR;
            end else if (last_level) begin
                cause = CAUSE_LAST_PTR;
            end else begin
                kind = KIND_PTR;
            end
        end else if (bad_enc) begin
            cause = CAUSE_BAD_ENC;
        end else begin
            kind = KIND_LEAF;
        end
    end
endmodule

// File: rtl/ptwchk_walk_fsm.sv
// Walk sequencer: tracks whether a walk is open and at which level.
// Starts at the top level, descends on a pointer, closes on leaf or fault.
// Assumes the classifier already turns a last-level pointer into a fault.
module ptwchk_walk_fsm
    import ptwchk_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int LVL_W  = 2
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             walk_start,
    input  logic             pte_valid,
    input  kind_e            kind,
    output logic             accept,
    output logic             busy,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] TOP_LEVEL = LVL_W'(LEVELS - 1);

    typedef enum logic {ST_IDLE = 1'b0, ST_WALK = 1'b1} state_e;

    state_e state;

    // Entries count only while a walk is open.
    always_comb begin
        busy   = (state == ST_WALK);
        accept = busy && pte_valid;
    end

    // Advance the walk state and the level counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            level <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (walk_start) begin
                        state <= ST_WALK;
                        level <= TOP_LEVEL;
                    end
                end
                default: begin
                    if (accept) begin
                        if (kind == KIND_PTR) begin
                            level <= level - 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ptw_pte_checker.sv
// Top: entry validity checker with its walk sequencer. Gates the
// memory-type field, classifies each accepted entry and registers the
// result for one cycle of valid. Assumes one entry per walk level.
module ptw_pte_checker
    import ptwchk_pkg::*;
#(
    parameter int               LEVELS   = 3,
    parameter logic [PTE_W-1:0] RSV_MASK = 64'h1FC0_0000_0000_0000,
    localparam int              LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               walk_start_i,
    input  logic               pte_valid_i,
    input  logic [PTE_W-1:0]   pte_i,
    input  logic               virt_i,
    input  logic               menv_mt_en_i,
    input  logic               henv_mt_en_i,
    input  logic               napot_ext_en_i,
    output logic               walk_busy_o,
    output logic               out_valid_o,
    output logic               leaf_o,
    output logic               fault_o,
    output logic [CAUSE_W-1:0] fault_cause_o,
    output logic [PPN_W-1:0]   next_ppn_o,
    output logic [LVL_W-1:0]   level_o
);
    logic             mt_off_flt;
    logic             mt_rsv_flt;
    logic             accept;
    logic [LVL_W-1:0] cur_level;
    logic             last_level;
    kind_e            kind;
    cause_e           cause;

    ptwchk_mtype_gate u_mtgate (
        .mtype      (pte_i[MT_LSB +: MT_W]),
        .virt       (virt_i),
        .menv_en    (menv_mt_en_i),
        .henv_en    (henv_mt_en_i),
        .mt_off_flt (mt_off_flt),
        .mt_rsv_flt (mt_rsv_flt)
    );

    // The lowest level may not hold a pointer.
    always_comb last_level = (cur_level == '0);

    ptwchk_classify #(.RSV_MASK(RSV_MASK)) u_class (
        .pte        (pte_i),
        .napot_en   (napot_ext_en_i),
        .mt_off_flt (mt_off_flt),
        .mt_rsv_flt (mt_rsv_flt),
        .last_level (last_level),
        .kind       (kind),
        .cause      (cause)
    );

    ptwchk_walk_fsm #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .walk_start (walk_start_i),
        .pte_valid  (pte_valid_i),
        .kind       (kind),
        .accept     (accept),
        .busy       (walk_busy_o),
        .level      (cur_level)
    );

    // Register the result of each accepted entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o   <= 1'b0;
            leaf_o        <= 1'b0;
            fault_o       <= 1'b0;
            fault_cause_o <= '0;
            next_ppn_o    <= '0;
            level_o       <= '0;
        end else begin
            out_valid_o <= accept;
            if (accept) begin
                leaf_o        <= (kind == KIND_LEAF);
                fault_o       <= (kind == KIND_FAULT);
                fault_cause_o <= cause;
                next_ppn_o    <= (kind == KIND_FAULT) ? '0 : pte_i[PPN_LSB +: PPN_W];
                level_o       <= cur_level;
            end
        end
    end
endmodule

// File: rtl/ptwchk_sva.sv
// Checker: timing and walk properties of the entry checker, bound to the top.
module ptwchk_sva
    import ptwchk_pkg::*;
#(
    parameter int LVL_W = 2
)(
    input logic               clk,
    input logic               rst_n,
    input logic               walk_start_i,
    input logic               pte_valid_i,
    input logic [MT_W-1:0]    pte_mt,
    input logic               virt_i,
    input logic               menv_mt_en_i,
    input logic               henv_mt_en_i,
    input logic               walk_busy_o,
    input logic               out_valid_o,
    input logic               leaf_o,
    input logic               fault_o,
    input logic [CAUSE_W-1:0] fault_cause_o,
    input logic [PPN_W-1:0]   next_ppn_o,
    input logic [LVL_W-1:0]   level_o
);
    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (pte_valid_i && walk_busy_o) |=> out_valid_o); // R10
    AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !(pte_valid_i && walk_busy_o) |=> !out_valid_o); // R13
    AST_LEAF_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !(leaf_o && fault_o)); // R9
    AST_FAULT_PPN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && fault_o) |-> (next_ppn_o == '0)); // R9
    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (!walk_busy_o && walk_start_i) |=> walk_busy_o); // R11
    AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && (leaf_o || fault_o)) |-> !walk_busy_o); // R11
    AST_PTR_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !leaf_o && !fault_o) |-> walk_busy_o); // R11
    AST_LAST_PTR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && fault_cause_o == 3'd7) |-> (level_o == '0)); // R12
    AST_MT_ENABLE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pte_valid_i && walk_busy_o && pte_mt != '0
         && (virt_i ? henv_mt_en_i : menv_mt_en_i)) |=> (fault_cause_o != 3'd3)); // R5
endmodule

bind ptw_pte_checker ptwchk_sva #(.LVL_W(LVL_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .walk_start_i  (walk_start_i),
    .pte_valid_i   (pte_valid_i),
    .pte_mt        (pte_i[62:61]),
    .virt_i        (virt_i),
    .menv_mt_en_i  (menv_mt_en_i),
    .henv_mt_en_i  (henv_mt_en_i),
    .walk_busy_o   (walk_busy_o),
    .out_valid_o   (out_valid_o),
    .leaf_o        (leaf_o),
    .fault_o       (fault_o),
    .fault_cause_o (fault_cause_o),
    .next_ppn_o    (next_ppn_o),
    .level_o       (level_o)
);

// File: tb/sim_ptw_pte_checker.sv
// Bench: behavioural reference model compared with the design on every clock.
module sim_ptw_pte_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_start_i = 1'b0;
    logic        pte_valid_i = 1'b0;
    logic [63:0] pte_i = '0;
    logic        virt_i = 1'b0;
    logic        menv_mt_en_i = 1'b0;
    logic        henv_mt_en_i = 1'b0;
    logic        napot_ext_en_i = 1'b0;
    logic        walk_busy_o, out_valid_o, leaf_o, fault_o;
    logic [2:0]  fault_cause_o;
    logic [43:0] next_ppn_o;
    logic [1:0]  level_o;

    localparam logic [63:0] PV = 64'h1, PR = 64'h2, PW = 64'h4, PX = 64'h8;
    localparam logic [63:0] PU = 64'h10, PG = 64'h20, PA = 64'h40, PD = 64'h80;
    localparam logic [63:0] PN = 64'h1 << 63;
    localparam logic [63:0] MT1 = 64'h1 << 61;
    localparam logic [63:0] MT3 = 64'h3 << 61;
    localparam logic [63:0] RSV54 = 64'h1 << 54;
    localparam logic [63:0] RSV60 = 64'h1 << 60;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string cur_tag = "R1";
    bit    done = 0;

    // reference state
    bit          m_busy = 0;
    int          m_level = 0;
    bit          m_ov = 0, m_leaf = 0, m_flt = 0;
    int          m_cause = 0;
    logic [43:0] m_ppn = '0;
    int          m_olvl = 0;

    always #5 clk = ~clk;

    ptw_pte_checker u0 (
        .clk(clk), .rst_n(rst_n), .walk_start_i(walk_start_i),
        .pte_valid_i(pte_valid_i), .pte_i(pte_i), .virt_i(virt_i),
        .menv_mt_en_i(menv_mt_en_i), .henv_mt_en_i(henv_mt_en_i),
        .napot_ext_en_i(napot_ext_en_i), .walk_busy_o(walk_busy_o),
        .out_valid_o(out_valid_o), .leaf_o(leaf_o), .fault_o(fault_o),
        .fault_cause_o(fault_cause_o), .next_ppn_o(next_ppn_o), .level_o(level_o)
    );

    function automatic bit ref_is_ptr(logic [63:0] p);
        return p[0] && !p[1] && !p[2] && !p[3];
    endfunction

    function automatic int ref_cause(logic [63:0] p, bit vt, bit me, bit he, bit ne, int lvl);
        bit mten;
        int mt;
        mten = vt ? he : me;
        mt = int'(p[62:61]);
        if (p[60:54] != 0) return 1;
        if (p[63] && !ne) return 2;
        if (mt != 0 && !mten) return 3;
        if (mt == 3) return 4;
        if (ref_is_ptr(p)) begin
            if (p[7] || p[6] || p[4] || p[63] || mt != 0) return 5;
            if (lvl == 0) return 7;
            return 0;
        end
        if (!p[0] || (p[2] && !p[1])) return 6;
        return 0;
    endfunction

    // Update the model at each edge, then compare after outputs settle.
    always @(posedge clk) begin
        int c;
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_level = 0; m_ov = 0; m_leaf = 0; m_flt = 0;
            m_cause = 0; m_ppn = '0; m_olvl = 0;
        end else begin
            m_ov = 0;
            if (m_busy && pte_valid_i) begin
                c = ref_cause(pte_i, virt_i, menv_mt_en_i, henv_mt_en_i, napot_ext_en_i, m_level);
                m_ov = 1;
                m_flt = (c != 0);
                m_leaf = !m_flt && !ref_is_ptr(pte_i);
                m_cause = c;
                m_ppn = m_flt ? 44'h0 : pte_i[53:10];
                m_olvl = m_level;
                if (!m_flt && ref_is_ptr(pte_i)) m_level = m_level - 1;
                else m_busy = 0;
            end else if (!m_busy && walk_start_i) begin
                m_busy = 1;
                m_level = 2;
            end
        end
        #2;
        vectors++;
        if (out_valid_o !== m_ov || walk_busy_o !== m_busy || leaf_o !== m_leaf ||
            fault_o !== m_flt || int'(fault_cause_o) != m_cause ||
            next_ppn_o !== m_ppn || int'(level_o) != m_olvl) begin
            miscompares++;
            $display("FAIL %s t=%0t act ov=%0b busy=%0b leaf=%0b flt=%0b cause=%0d ppn=%h lvl=%0d exp ov=%0b busy=%0b leaf=%0b flt=%0b cause=%0d ppn=%h lvl=%0d",
                     cur_tag, $time, out_valid_o, walk_busy_o, leaf_o, fault_o, fault_cause_o,
                     next_ppn_o, level_o, m_ov, m_busy, m_leaf, m_flt, m_cause, m_ppn, m_olvl);
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog act=%0d cycles exp<=20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start_walk();
        walk_start_i = 1'b1;
        @(negedge clk);
        walk_start_i = 1'b0;
    endtask

    task automatic feed(logic [63:0] p);
        pte_i = p;
        pte_valid_i = 1'b1;
        @(negedge clk);
        pte_valid_i = 1'b0;
        pte_i = '0;
    endtask

    task automatic single(logic [63:0] p, string tag);
        cur_tag = tag;
        start_walk();
        feed(p);
        idle(2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        cur_tag = "R1";
        idle(2);

        // R9: plain leaf, and R+W+X leaf with page number
        single(PV | PR | PX | (64'h123 << 10), "R9");
        single(PV | PR | PW | PX | PG | PA | PD | (64'hABCDE << 10), "R9");

        // R11: descend 2 -> 1 -> 0 and end on a leaf; G allowed on pointer
        cur_tag = "R11";
        start_walk();
        feed(PV | (64'h11 << 10));
        idle(1);
        feed(PV | PG | (64'h22 << 10));
        feed(PV | PR | (64'h33 << 10));
        idle(2);

        // R12: pointer at level 0
        cur_tag = "R12";
        start_walk();
        feed(PV | (64'h1 << 10));
        feed(PV | (64'h2 << 10));
        feed(PV | (64'h3 << 10));
        idle(2);

        // R2: reserved bits outrank NAPOT and reserved memory type
        napot_ext_en_i = 1'b0;
        single(PV | PR | RSV54 | PN | MT3, "R2");
        single(PV | RSV60, "R2");

        // R3: NAPOT bit gated by the extension input
        single(PV | PR | PN, "R3");
        napot_ext_en_i = 1'b1;
        single(PV | PR | PN | (64'h77 << 10), "R3");

        // R4: nonzero memory type with enable off
        virt_i = 1'b0; menv_mt_en_i = 1'b0; henv_mt_en_i = 1'b1;
        single(PV | PR | MT1, "R4");

        // R5: enable source chosen by virtualization mode
        virt_i = 1'b1; menv_mt_en_i = 1'b0; henv_mt_en_i = 1'b1;
        single(PV | PR | MT1 | (64'h5 << 10), "R5");
        virt_i = 1'b1; menv_mt_en_i = 1'b1; henv_mt_en_i = 1'b0;
        single(PV | PR | MT1, "R5");
        virt_i = 1'b0; menv_mt_en_i = 1'b1; henv_mt_en_i = 1'b0;
        single(PV | PR | MT1 | (64'h6 << 10), "R5");

        // R6: memory type value 3 reserved; enable-off outranks it
        single(PV | PR | MT3, "R6");
        menv_mt_en_i = 1'b0;
        single(PV | PR | MT3, "R6");
        menv_mt_en_i = 1'b1;

        // R7: pointer attribute checks
        single(PV | PA, "R7");
        single(PV | PD, "R7");
        single(PV | PU, "R7");
        single(PV | MT1, "R7");
        single(PV | PN, "R7");

        // R8: bad encodings
        single(PR | PX, "R8");
        single(64'h0, "R8");
        single(PV | PW, "R8");
        single(PV | PW | PX, "R8");

        // R10: gap between accepted entries keeps valid a single pulse
        cur_tag = "R10";
        start_walk();
        idle(3);
        feed(PV | (64'h9 << 10));
        idle(3);
        feed(PV | PX | (64'hA << 10));
        idle(2);

        // R13: entry while idle ignored; start while busy ignored
        cur_tag = "R13";
        feed(PV | PR | (64'h44 << 10));
        idle(1);
        start_walk();
        walk_start_i = 1'b1;
        feed(PV | (64'h55 << 10));
        walk_start_i = 1'b0;
        start_walk();
        feed(PV | PR | (64'h66 << 10));
        idle(2);

        // R1: reset mid-walk returns to the reset state
        cur_tag = "R1";
        start_walk();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule